// File: doc/BRIEF.md
# Domain-Tagged DMA Translation Cache

This block is a small fully associative cache of finished DMA address translations that sits in front of a page-table walker. Each lookup carries a domain identifier, a virtual page number and an access type (read or write). When the cache holds a translation for that domain and page, it answers in the same cycle with the physical frame and a flag that says whether the access type is permitted. When it does not, it raises a miss so that the caller starts a walk. The caller then writes the walk result back through the fill port.

Software keeps the cache consistent with the translation tables by issuing invalidation commands through a register-style request port. There are three kinds. A global command drops everything. A domain command drops every entry of one domain. A page-range command drops the entries of one domain whose page number lies in an aligned block of 2^k pages. A command takes one sweep cycle, during which lookups are held off. A one-cycle completion pulse follows the sweep. When every slot is occupied, the least recently used entry is replaced.

Top module: `dma_xlate_cache`

## Requirements
- R1: After reset no entry is valid: every lookup reports a miss, and inv_busy and inv_done are low.
- R2: Once a fill has been taken on a clock edge, a lookup from the next cycle onward with the same domain and page reports lk_hit in that same cycle and returns the filled frame on lk_pfn.
- R3: The domain is part of the tag. A lookup with a matching page but a different domain reports a miss.
- R4: On a hit, lk_denied is high when lk_write=1 (write) and the entry's write permission is 0, or when lk_write=0 (read) and its read permission is 0. Otherwise lk_denied is low. lk_denied is low on a miss.
- R5: A command with inv_kind=2'b00 (global) leaves no entry valid.
- R6: A command with inv_kind=2'b01 (domain) removes exactly the entries whose domain equals inv_did.
- R7: A command with inv_kind=2'b10 or 2'b11 (page range) removes exactly the entries whose domain equals inv_did and whose page number equals inv_vpn in every bit at or above position inv_amask. An inv_amask of VPN_W or more covers the whole domain.
- R8: The cache accepts inv_req only while idle. inv_busy is high in the next cycle, and in that cycle lk_hit and lk_miss both stay low. inv_done is high for exactly the one cycle after that, with inv_busy low. An inv_req that arrives while inv_busy is high is ignored.
- R9: A fill in the sweep cycle is ordered after the sweep. If it matches the command being swept, it is not left valid. If it does not match, it is stored.
- R10: A fill with a new tag takes the lowest-numbered invalid slot. If no slot is invalid, it evicts the entry least recently touched, where both a lookup hit and a fill count as a touch.
- R11: A fill whose domain and page are already cached overwrites that entry in place. The next lookup returns the new frame and permissions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_did | input | DID_W | Lookup domain |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_write | input | 1 | Access type: 1 write, 0 read |
| lk_hit | output | 1 | Lookup found a matching entry |
| lk_miss | output | 1 | Lookup found nothing; walk required |
| lk_denied | output | 1 | Hit, but the access type is not permitted |
| lk_pfn | output | PFN_W | Physical frame on a hit, zero otherwise |
| fill_valid | input | 1 | Walk result to insert |
| fill_did | input | DID_W | Fill domain |
| fill_vpn | input | VPN_W | Fill virtual page number |
| fill_pfn | input | PFN_W | Fill physical frame |
| fill_r | input | 1 | Fill read permission |
| fill_w | input | 1 | Fill write permission |
| inv_req | input | 1 | Invalidation command strobe |
| inv_kind | input | 2 | 00 global, 01 domain, 1x page range |
| inv_did | input | DID_W | Command domain |
| inv_vpn | input | VPN_W | Range base page |
| inv_amask | input | AM_W | Number of low page bits ignored by a range command |
| inv_busy | output | 1 | Sweep cycle in progress; lookups stalled |
| inv_done | output | 1 | One-cycle completion pulse |

## Verification
A stale valid bit left behind by a sweep shows up as a hit on a later lookup, with a frame that software believes has been withdrawn. A fill that lands in the wrong slot shows up as an unexpected miss on a still-live page, but only once the cache is full enough for the wrong victim to matter. A corrupted recency order therefore stays hidden until the next eviction, so the bench runs long random sequences over a small pool of pages with the cache full. After every command and every fill, it compares each lookup against a reference model, cycle by cycle.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_SWEEP = 1'b1
    } phase_e;

    localparam logic [1:0] KIND_GLOBAL = 2'b00;
    localparam logic [1:0] KIND_DOMAIN = 2'b01;
endpackage

// File: rtl/xlc_tag_cmp.sv
module xlc_tag_cmp #(
    parameter int DID_W = 8,
    parameter int VPN_W = 20,
    parameter int AM_W  = 5
) (
    input  logic [DID_W-1:0] ent_did,
    input  logic [VPN_W-1:0] ent_vpn,
    input  logic [DID_W-1:0] ref_did,
    input  logic [VPN_W-1:0] ref_vpn,
    input  logic [AM_W-1:0]  ref_amask,
    output logic             did_eq,
    output logic             vpn_eq
);
    always_comb begin
        did_eq = (ent_did == ref_did);
        vpn_eq = 1'b1;
        for (int b = 0; b < VPN_W; b++) begin
            if ((ent_vpn[b] != ref_vpn[b]) && (b >= int'(ref_amask))) begin
                vpn_eq = 1'b0;
            end
        end
    end
endmodule

// File: rtl/xlc_lru.sv
module xlc_lru #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] victim_idx
);
    logic [N-1:0][IDX_W-1:0] age_d, age_q;
    logic [N-1:0]            oldest;

    always_comb begin
        age_d      = age_q;
        victim_idx = '0;
        for (int i = 0; i < N; i++) begin
            oldest[i] = (age_q[i] == IDX_W'(N - 1));
            if (oldest[i]) victim_idx = IDX_W'(i);
            if (touch_en) begin
                if (IDX_W'(i) == touch_idx)          age_d[i] = '0;
                else if (age_q[i] < age_q[touch_idx]) age_d[i] = age_q[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
        end else begin
            age_q <= age_d;
        end
    end

    // R10: the recency order stays a permutation, so exactly one victim exists
    p_single_victim_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest) == 1);

    // R10: a touched slot is the most recent one on the next cycle
    p_touch_youngest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> age_q[$past(touch_idx)] == '0);
endmodule

// File: rtl/dma_xlate_cache.sv
module dma_xlate_cache #(
    parameter int N     = 16,
    parameter int DID_W = 8,
    parameter int VPN_W = 20,
    parameter int PFN_W = 20,
    parameter int AM_W  = $clog2(VPN_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [DID_W-1:0] lk_did,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             lk_write,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_denied,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             fill_valid,
    input  logic [DID_W-1:0] fill_did,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_r,
    input  logic             fill_w,
    input  logic             inv_req,
    input  logic [1:0]       inv_kind,
    input  logic [DID_W-1:0] inv_did,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic [AM_W-1:0]  inv_amask,
    output logic             inv_busy,
    output logic             inv_done
);
    import xlc_pkg::*;

    localparam int IDX_W = $clog2(N);

    typedef struct packed {
        phase_e                  phase;
        logic                    done;
        logic [1:0]              kind;
        logic [DID_W-1:0]        did;
        logic [VPN_W-1:0]        vpn;
        logic [AM_W-1:0]         amask;
        logic [N-1:0]            vld;
        logic [N-1:0][DID_W-1:0] e_did;
        logic [N-1:0][VPN_W-1:0] e_vpn;
        logic [N-1:0][PFN_W-1:0] e_pfn;
        logic [N-1:0]            e_r;
        logic [N-1:0]            e_w;
    } xlc_state_t;

    xlc_state_t st_d, st_q;

    logic [N-1:0] lk_did_eq, lk_vpn_eq, fl_did_eq, fl_vpn_eq, iv_did_eq, iv_vpn_eq;
    logic [N-1:0] lk_vec, fl_vec, iv_vec;
    logic         fc_did_eq, fc_vpn_eq, fill_cmd_hit;
    logic [IDX_W-1:0] hit_idx, fill_idx, victim_idx;
    logic         touch_en;
    logic [IDX_W-1:0] touch_idx;
    logic         ready, sweep;

    // per-entry tag comparators: lookup, fill and invalidation command
    for (genvar g = 0; g < N; g++) begin : g_ent
        xlc_tag_cmp #(.DID_W(DID_W), .VPN_W(VPN_W), .AM_W(AM_W)) i_lk_cmp (
            .ent_did(st_q.e_did[g]), .ent_vpn(st_q.e_vpn[g]),
            .ref_did(lk_did), .ref_vpn(lk_vpn), .ref_amask('0),
            .did_eq(lk_did_eq[g]), .vpn_eq(lk_vpn_eq[g]));
        xlc_tag_cmp #(.DID_W(DID_W), .VPN_W(VPN_W), .AM_W(AM_W)) i_fl_cmp (
            .ent_did(st_q.e_did[g]), .ent_vpn(st_q.e_vpn[g]),
            .ref_did(fill_did), .ref_vpn(fill_vpn), .ref_amask('0),
            .did_eq(fl_did_eq[g]), .vpn_eq(fl_vpn_eq[g]));
        xlc_tag_cmp #(.DID_W(DID_W), .VPN_W(VPN_W), .AM_W(AM_W)) i_iv_cmp (
            .ent_did(st_q.e_did[g]), .ent_vpn(st_q.e_vpn[g]),
            .ref_did(st_q.did), .ref_vpn(st_q.vpn), .ref_amask(st_q.amask),
            .did_eq(iv_did_eq[g]), .vpn_eq(iv_vpn_eq[g]));

        assign lk_vec[g] = st_q.vld[g] & lk_did_eq[g] & lk_vpn_eq[g];
        assign fl_vec[g] = st_q.vld[g] & fl_did_eq[g] & fl_vpn_eq[g];
        assign iv_vec[g] = st_q.vld[g] & ((st_q.kind == KIND_GLOBAL) |
                           (iv_did_eq[g] & ((st_q.kind == KIND_DOMAIN) | iv_vpn_eq[g])));

        // R5 R6 R7: a swept entry that is not refilled in the same cycle is gone
        p_swept_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (sweep && iv_vec[g] && !(fill_valid && fill_idx == IDX_W'(g)))
            |=> !st_q.vld[g]);
    end

    // the fill tag compared with the command being swept
    xlc_tag_cmp #(.DID_W(DID_W), .VPN_W(VPN_W), .AM_W(AM_W)) i_fc_cmp (
        .ent_did(fill_did), .ent_vpn(fill_vpn),
        .ref_did(st_q.did), .ref_vpn(st_q.vpn), .ref_amask(st_q.amask),
        .did_eq(fc_did_eq), .vpn_eq(fc_vpn_eq));

    assign fill_cmd_hit = (st_q.kind == KIND_GLOBAL) |
                          (fc_did_eq & ((st_q.kind == KIND_DOMAIN) | fc_vpn_eq));

    xlc_lru #(.N(N), .IDX_W(IDX_W)) i_lru (
        .clk(clk), .rst_n(rst_n), .touch_en(touch_en),
        .touch_idx(touch_idx), .victim_idx(victim_idx));

    assign ready = (st_q.phase == PH_IDLE);
    assign sweep = (st_q.phase == PH_SWEEP);

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (lk_vec[i]) hit_idx = hit_idx | IDX_W'(i);
        end
        // slot choice: existing tag, else lowest invalid slot, else LRU victim
        fill_idx = victim_idx;
        for (int i = N - 1; i >= 0; i--) begin
            if (!st_q.vld[i]) fill_idx = IDX_W'(i);
        end
        for (int i = 0; i < N; i++) begin
            if (fl_vec[i]) fill_idx = IDX_W'(i);
        end

        lk_hit    = lk_valid & ready & (|lk_vec);
        lk_miss   = lk_valid & ready & ~(|lk_vec);
        lk_pfn    = lk_hit ? st_q.e_pfn[hit_idx] : '0;
        lk_denied = lk_hit & (lk_write ? ~st_q.e_w[hit_idx] : ~st_q.e_r[hit_idx]);

        touch_en  = fill_valid | lk_hit;
        touch_idx = fill_valid ? fill_idx : hit_idx;

        st_d      = st_q;
        st_d.done = 1'b0;

        if (ready && inv_req) begin
            st_d.phase = PH_SWEEP;
            st_d.kind  = inv_kind;
            st_d.did   = inv_did;
            st_d.vpn   = inv_vpn;
            st_d.amask = inv_amask;
        end

        if (sweep) begin
            for (int i = 0; i < N; i++) begin
                if (iv_vec[i] && !(fill_valid && fill_idx == IDX_W'(i))) st_d.vld[i] = 1'b0;
            end
            st_d.phase = PH_IDLE;
            st_d.done  = 1'b1;
        end

        if (fill_valid) begin
            st_d.vld[fill_idx]   = !(sweep && fill_cmd_hit);
            st_d.e_did[fill_idx] = fill_did;
            st_d.e_vpn[fill_idx] = fill_vpn;
            st_d.e_pfn[fill_idx] = fill_pfn;
            st_d.e_r[fill_idx]   = fill_r;
            st_d.e_w[fill_idx]   = fill_w;
        end

        inv_busy = sweep;
        inv_done = st_q.done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: completion is a single-cycle pulse that follows the sweep cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inv_done |=> !inv_done);
    p_busy_then_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inv_busy |=> (inv_done && !inv_busy));
    // R8: no lookup answer while stalled
    p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inv_busy |-> (!lk_hit && !lk_miss));
    // R11: refills in place keep tags unique
    p_unique_tag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec));
    // R9: a fill that matches the swept command does not survive
    p_fill_swept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep && fill_valid && fill_cmd_hit) |=> !st_q.vld[$past(fill_idx)]);
    // R2: a fill outside a sweep leaves its slot valid
    p_fill_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && fill_valid) |=> st_q.vld[$past(fill_idx)]);
endmodule

// File: tb/test_dma_xlate_cache.sv
module test_dma_xlate_cache;
    localparam int N = 16, DID_W = 8, VPN_W = 20, PFN_W = 20;
    localparam int AM_W = $clog2(VPN_W + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic lk_valid = 1'b0, lk_write = 1'b0;
    logic [DID_W-1:0] lk_did = '0;
    logic [VPN_W-1:0] lk_vpn = '0;
    logic lk_hit, lk_miss, lk_denied;
    logic [PFN_W-1:0] lk_pfn;
    logic fill_valid = 1'b0, fill_r = 1'b0, fill_w = 1'b0;
    logic [DID_W-1:0] fill_did = '0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [PFN_W-1:0] fill_pfn = '0;
    logic inv_req = 1'b0;
    logic [1:0] inv_kind = '0;
    logic [DID_W-1:0] inv_did = '0;
    logic [VPN_W-1:0] inv_vpn = '0;
    logic [AM_W-1:0] inv_amask = '0;
    logic inv_busy, inv_done;

    always #2 clk = ~clk;   // 250 MHz

    dma_xlate_cache #(.N(N), .DID_W(DID_W), .VPN_W(VPN_W), .PFN_W(PFN_W)) i_dma_xlate_cache (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_did(lk_did), .lk_vpn(lk_vpn), .lk_write(lk_write),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_denied(lk_denied), .lk_pfn(lk_pfn),
        .fill_valid(fill_valid), .fill_did(fill_did), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .fill_r(fill_r), .fill_w(fill_w),
        .inv_req(inv_req), .inv_kind(inv_kind), .inv_did(inv_did), .inv_vpn(inv_vpn),
        .inv_amask(inv_amask), .inv_busy(inv_busy), .inv_done(inv_done));

    int errors = 0, checks = 0;
    int unsigned now_ts = 0;

    // reference model
    bit          m_v[N];
    int unsigned m_did[N], m_vpn[N], m_pfn[N], m_ts[N];
    bit          m_r[N], m_w[N];

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int m_find(int unsigned d, int unsigned v);
        for (int i = 0; i < N; i++) if (m_v[i] && m_did[i] == d && m_vpn[i] == v) return i;
        return -1;
    endfunction

    function automatic int m_slot(int unsigned d, int unsigned v);
        int s;
        int unsigned best;
        s = m_find(d, v);
        if (s >= 0) return s;
        for (int i = 0; i < N; i++) if (!m_v[i]) return i;
        best = m_ts[0]; s = 0;
        for (int i = 1; i < N; i++) if (m_ts[i] < best) begin best = m_ts[i]; s = i; end
        return s;
    endfunction

    function automatic bit m_cmd_hit(int unsigned d, int unsigned v, int kind,
                                     int unsigned cd, int unsigned cv, int am);
        if (kind == 0) return 1'b1;
        if (d != cd) return 1'b0;
        if (kind == 1) return 1'b1;
        return ((v ^ cv) >> am) == 0;
    endfunction

    task automatic m_fill(int unsigned d, int unsigned v, int unsigned p, bit r, bit w);
        int s;
        s = m_slot(d, v);
        m_v[s] = 1'b1; m_did[s] = d; m_vpn[s] = v; m_pfn[s] = p; m_r[s] = r; m_w[s] = w;
        now_ts++; m_ts[s] = now_ts;
    endtask

    task automatic do_lookup(int unsigned d, int unsigned v, bit wr, string req);
        int s;
        bit eh, ed;
        @(negedge clk);
        lk_valid = 1'b1; lk_did = DID_W'(d); lk_vpn = VPN_W'(v); lk_write = wr;
        #1;
        s  = m_find(d, v);
        eh = (s >= 0);
        ed = eh && (wr ? !m_w[s] : !m_r[s]);
        check(lk_hit == eh, req, "lk_hit", lk_hit, eh);
        check(lk_miss == !eh, req, "lk_miss", lk_miss, !eh);
        check(lk_denied == ed, req, "lk_denied", lk_denied, ed);
        if (eh) check(lk_pfn == PFN_W'(m_pfn[s]), req, "lk_pfn", lk_pfn, m_pfn[s]);
        @(posedge clk);
        #1 lk_valid = 1'b0;
        if (eh) begin now_ts++; m_ts[s] = now_ts; end
    endtask

    task automatic do_fill(int unsigned d, int unsigned v, int unsigned p, bit r, bit w);
        @(negedge clk);
        fill_valid = 1'b1; fill_did = DID_W'(d); fill_vpn = VPN_W'(v);
        fill_pfn = PFN_W'(p); fill_r = r; fill_w = w;
        @(posedge clk);
        #1 fill_valid = 1'b0;
        m_fill(d, v, p, r, w);
    endtask

    task automatic do_inv(int kind, int unsigned d, int unsigned v, int am,
                          bit with_fill, int unsigned fd, int unsigned fv, int unsigned fp,
                          bit extra_req, string req);
        @(negedge clk);
        inv_req = 1'b1; inv_kind = 2'(kind); inv_did = DID_W'(d);
        inv_vpn = VPN_W'(v); inv_amask = AM_W'(am);
        @(posedge clk);
        #1 inv_req = 1'b0;
        @(negedge clk);
        check(inv_busy == 1'b1, "R8", "inv_busy in sweep", inv_busy, 1);
        lk_valid = 1'b1; lk_did = DID_W'(d); lk_vpn = VPN_W'(v); lk_write = 1'b0;
        if (with_fill) begin
            fill_valid = 1'b1; fill_did = DID_W'(fd); fill_vpn = VPN_W'(fv);
            fill_pfn = PFN_W'(fp); fill_r = 1'b1; fill_w = 1'b1;
        end
        if (extra_req) begin inv_req = 1'b1; inv_kind = 2'b00; end
        #1;
        check(!lk_hit && !lk_miss, "R8", "lookup stalled", {lk_hit, lk_miss}, 0);
        @(posedge clk);
        #1 lk_valid = 1'b0; fill_valid = 1'b0; inv_req = 1'b0;
        if (with_fill) m_fill(fd, fv, fp, 1'b1, 1'b1);
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_cmd_hit(m_did[i], m_vpn[i], kind, d, v, am)) m_v[i] = 1'b0;
        @(negedge clk);
        check(inv_done == 1'b1 && inv_busy == 1'b0, req, "done pulse", {inv_done, inv_busy}, 2);
        @(posedge clk);
        @(negedge clk);
        check(inv_done == 1'b0 && inv_busy == 1'b0, "R8", "done ends, extra req ignored",
              {inv_done, inv_busy}, 0);
    endtask

    task automatic sweep_all_lookups(int unsigned d, string req);
        for (int v = 0; v < 20; v++) do_lookup(d, v, 1'b0, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'd7321);
        for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check(inv_busy == 1'b0 && inv_done == 1'b0, "R1", "flags after reset",
              {inv_busy, inv_done}, 0);
        do_lookup(1, 5, 1'b0, "R1");

        // R2, R4: fill and hit with permissions
        do_fill(1, 5, 20'hABCDE, 1'b1, 1'b0);
        do_lookup(1, 5, 1'b0, "R2");
        do_lookup(1, 5, 1'b1, "R4");
        do_fill(1, 6, 20'h12345, 1'b0, 1'b1);
        do_lookup(1, 6, 1'b0, "R4");
        do_lookup(1, 6, 1'b1, "R4");
        // R3: domain is part of the tag
        do_lookup(2, 5, 1'b0, "R3");
        // R11: overwrite in place
        do_fill(1, 5, 20'h55555, 1'b1, 1'b1);
        do_lookup(1, 5, 1'b1, "R11");

        // R7: aligned range of 4 pages at 8, domain 1; neighbours and domain 2 survive
        for (int v = 4; v < 16; v++) do_fill(1, v, 32'h100 + v, 1'b1, 1'b1);
        do_fill(2, 9, 20'h777, 1'b1, 1'b1);
        do_inv(2, 1, 9, 2, 1'b0, 0, 0, 0, 1'b0, "R7");
        sweep_all_lookups(1, "R7");
        do_lookup(2, 9, 1'b0, "R7");
        // R7: mask beyond the page width covers the domain
        do_inv(3, 1, 0, VPN_W, 1'b0, 0, 0, 0, 1'b0, "R7");
        sweep_all_lookups(1, "R7");
        do_lookup(2, 9, 1'b0, "R7");

        // R6: domain command, with an ignored second request during the sweep (R8)
        do_fill(1, 3, 20'h333, 1'b1, 1'b1);
        do_inv(1, 2, 0, 0, 1'b0, 0, 0, 0, 1'b1, "R6");
        do_lookup(2, 9, 1'b0, "R6");
        do_lookup(1, 3, 1'b0, "R8");

        // R9: fill during sweep, matching and not matching
        do_inv(1, 1, 0, 0, 1'b1, 1, 40, 20'h4040, 1'b0, "R9");
        do_lookup(1, 40, 1'b0, "R9");
        do_inv(1, 3, 0, 0, 1'b1, 2, 41, 20'h4141, 1'b0, "R9");
        do_lookup(2, 41, 1'b0, "R9");

        // R5: global
        do_inv(0, 0, 0, 0, 1'b0, 0, 0, 0, 1'b0, "R5");
        do_lookup(2, 41, 1'b0, "R5");

        // R10: fill all slots, touch the oldest, next fill evicts the second oldest
        for (int v = 100; v < 100 + N; v++) do_fill(1, v, 32'h900 + v, 1'b1, 1'b1);
        do_lookup(1, 100, 1'b0, "R10");
        do_fill(1, 200, 20'hC8, 1'b1, 1'b1);
        do_lookup(1, 101, 1'b0, "R10");
        do_lookup(1, 100, 1'b0, "R10");
        do_lookup(1, 200, 1'b0, "R10");

        // random mix over a small pool so the cache stays full and sweeps hit
        for (int n = 0; n < 1500; n++) begin
            int unsigned sel, d, v, am, k;
            sel = $urandom % 100;
            d   = $urandom % 3;
            v   = $urandom % 48;
            if (sel < 55) begin
                do_lookup(d, v, 1'($urandom), "R10");
            end else if (sel < 88) begin
                do_fill(d, v, $urandom, 1'($urandom), 1'($urandom));
            end else begin
                k  = $urandom % 4;
                am = ($urandom % 5 == 0) ? VPN_W : $urandom % 4;
                do_inv(k, d, v, am, ($urandom % 3 == 0), $urandom % 3, $urandom % 48,
                       $urandom, 1'b0, (k == 0) ? "R5" : (k == 1) ? "R6" : "R7");
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule